// File: doc/BRIEF.md
# BCD Calendar Clock with Hundredths

This block is a real-time calendar kept entirely in packed BCD. A 100 Hz enable pulse advances a hundredths-of-a-second count. That count carries in turn into seconds, minutes, hours, day of week, date, month and a two-digit year. The length of each month comes from the month and the year, so 30-day months, February and leap years all end on the right date. Hours run in either a 24-hour format or a 12-hour format with an AM/PM flag. A stop bit freezes the whole count.

The full state is visible at all times as eight 8-bit registers on one 64-bit bus, with register N in bits 8N+7..8N. A single-cycle load replaces all eight registers from a 64-bit word. Bit positions that hold no state read as zero. The mode bit, the AM/PM flag, the stop bit and a stored reset-enable bit share the hours and day registers with the counts. Counting never disturbs these control bits.

Top module: `bcd_calendar`

## Requirements
- R1: After synchronous reset the registers read, from register 0 to 7: 00, 00, 00, 00, 31, 01, 01, 00 (hex). Time is 00:00:00.00 in 24-hour mode, day 1, date 01, month 01, year 00, and both control bits in register 4 are 1.
- R2: Register 0 holds tenths in bits 7:4 and hundredths in bits 3:0. Each tick with counting enabled adds one hundredth in BCD. 99 wraps to 00 and advances the seconds. A cycle without a tick changes nothing.
- R3: Registers 1 (seconds) and 2 (minutes) count 00–59 in BCD. 59 wraps to 00 and carries into the next register.
- R4: When register 3 bit 7 is 0 (24-hour mode), bits 5:0 are hours 00–23 in BCD. 23 wraps to 00 and advances the day.
- R5: When register 3 bit 7 is 1 (12-hour mode), bits 4:0 are hours 01–12 in BCD and bit 5 is 1 for PM. 11 goes to 12 and toggles bit 5, and 12 goes to 01. Only the move from 11 PM to 12 AM advances the day.
- R6: Register 4 bits 2:0 are the day of week 1–7. It advances on each new day, and 7 wraps to 1.
- R7: Register 5 is the date in BCD. After date 30 in months 04, 06, 09 and 11, or after 31 in the other months (register 6), the date returns to 01 and the month advances.
- R8: In month 02 the last date is 29 when the BCD year (register 7) is a multiple of 4, 00 included, and 28 otherwise.
- R9: Register 6 is the month 01–12, and 12 wraps to 01 and advances register 7. The year counts 00–99, and 99 wraps to 00.
- R10: While register 4 bit 5 (stop) is 1, ticks change nothing. A load still takes effect.
- R11: A load replaces all registers in the next cycle, and it wins over a tick in the same cycle. Register bits with no state read as 0.
- R12: The mode bit, register 4 bit 4 (reset-enable) and the stop bit change only by load. They hold through every rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 100 Hz count enable, one clock wide |
| load | input | 1 | Replace all registers from load_data |
| load_data | input | 64 | Register image, register N in bits 8N+7..8N |
| regs_out | output | 64 | Current register image, same layout |

## Verification
The bench aims at the places where carries chain or a mode changes the sequence. These are the last hundredth of a year, the 11-to-12 step in 12-hour mode, February in leap and common years including year 00 and year 10, and the end of 30-day months. A design that handled any of these wrong would show up as a wrong value at one clock. It might skip or repeat a date, keep AM across noon, or advance the day at noon. It might also treat year 10 as a leap year because it tested the raw nibble. The bench also loads in the same cycle as a tick, and it ticks with the stop bit set. A design that lets the tick win would show a value one hundredth too high, and one that ignores the stop bit would keep counting.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    localparam int NUM_REGS = 8;
    localparam int REG_W    = 8;
    localparam int BUS_W    = NUM_REGS * REG_W;
    localparam int CHAIN_N  = 3;

    // bits of each register that hold state; the rest read as zero
    localparam logic [BUS_W-1:0] STORE_MASK = 64'hFF1F_3F37_BF7F_7FFF;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    typedef struct packed {
        logic       mode12;
        logic       hi5;
        logic       hi4;
        logic [3:0] ones;
    } hour_t;

    typedef struct packed {
        logic       osc_off;
        logic       rst_en;
        logic [2:0] dow;
        bcd2_t      date;
        bcd2_t      month;
        bcd2_t      year;
    } date_t;

    typedef struct packed {
        date_t                      d;
        hour_t                      h;
        logic [CHAIN_N*REG_W-1:0]   t;
    } cal_state_t;

    function automatic bcd2_t bcd_inc(bcd2_t v);
        bcd2_t r;
        if (v.ones == 4'd9) begin
            r.tens = v.tens + 4'd1;
            r.ones = 4'd0;
        end else begin
            r.tens = v.tens;
            r.ones = v.ones + 4'd1;
        end
        return r;
    endfunction

    function automatic logic [7:0] chain_limit(int idx);
        return (idx == 0) ? 8'h99 : 8'h59;
    endfunction

    function automatic logic is_leap(bcd2_t y);
        if (y.tens[0])
            return (y.ones == 4'd2) || (y.ones == 4'd6);
        else
            return (y.ones == 4'd0) || (y.ones == 4'd4) || (y.ones == 4'd8);
    endfunction

    function automatic bcd2_t last_date(bcd2_t m, bcd2_t y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic cal_state_t unpack_regs(logic [BUS_W-1:0] raw);
        logic [BUS_W-1:0] m;
        cal_state_t s;
        m = raw & STORE_MASK;
        s.t         = m[23:0];
        s.h.mode12  = m[31];
        s.h.hi5     = m[29];
        s.h.hi4     = m[28];
        s.h.ones    = m[27:24];
        s.d.osc_off = m[37];
        s.d.rst_en  = m[36];
        s.d.dow     = m[34:32];
        s.d.date    = m[47:40];
        s.d.month   = m[55:48];
        s.d.year    = m[63:56];
        return s;
    endfunction

    function automatic logic [BUS_W-1:0] pack_regs(cal_state_t s);
        return {s.d.year, s.d.month, s.d.date,
                2'b00, s.d.osc_off, s.d.rst_en, 1'b0, s.d.dow,
                s.h.mode12, 1'b0, s.h.hi5, s.h.hi4, s.h.ones,
                s.t};
    endfunction

endpackage

// File: rtl/bcd_mod_ctr.sv
module bcd_mod_ctr
    import bcd_cal_pkg::*;
#(
    parameter logic [7:0] MAX = 8'h59
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  bcd2_t load_val,
    input  logic  inc,
    output bcd2_t val,
    output logic  wrap
);

    assign wrap = inc && (val == bcd2_t'(MAX));

    always_ff @(posedge clk) begin
        if (rst)
            val <= '0;
        else if (load)
            val <= load_val;
        else if (wrap)
            val <= '0;
        else if (inc)
            val <= bcd_inc(val);
    end

    // R2 / R3: a counter at its limit returns to zero on the next step
    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && val == bcd2_t'(MAX)) |=> (val == '0));

    // R2: without a step or load the value holds
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load) |=> $stable(val));

endmodule

// File: rtl/cal_time_chain.sv
module cal_time_chain
    import bcd_cal_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [CHAIN_N*REG_W-1:0] load_vals,
    input  logic                     inc,
    output logic [CHAIN_N*REG_W-1:0] vals,
    output logic                     carry_out
);

    logic [CHAIN_N:0] step;
    assign step[0]   = inc;
    assign carry_out = step[CHAIN_N];

    for (genvar i = 0; i < CHAIN_N; i++) begin : g_stage
        bcd2_t stage_q;
        bcd_mod_ctr #(.MAX(chain_limit(i))) u_ctr (
            .clk      (clk),
            .rst      (rst),
            .load     (load),
            .load_val (bcd2_t'(load_vals[i*REG_W +: REG_W])),
            .inc      (step[i]),
            .val      (stage_q),
            .wrap     (step[i+1])
        );
        assign vals[i*REG_W +: REG_W] = stage_q;
    end

endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
    import bcd_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  hour_t load_val,
    input  logic  inc,
    output hour_t h,
    output logic  day_carry
);

    hour_t h_next;
    logic  roll;

    always_comb begin
        h_next = h;
        roll   = 1'b0;
        if (h.mode12) begin
            if (h.hi4 && h.ones == 4'd2) begin
                h_next.hi4  = 1'b0;
                h_next.ones = 4'd1;
            end else if (h.hi4 && h.ones == 4'd1) begin
                h_next.ones = 4'd2;
                h_next.hi5  = ~h.hi5;
                roll        = h.hi5;
            end else if (h.ones == 4'd9) begin
                h_next.hi4  = 1'b1;
                h_next.ones = 4'd0;
            end else begin
                h_next.ones = h.ones + 4'd1;
            end
        end else begin
            if ({h.hi5, h.hi4} == 2'b10 && h.ones == 4'd3) begin
                h_next.hi5  = 1'b0;
                h_next.hi4  = 1'b0;
                h_next.ones = 4'd0;
                roll        = 1'b1;
            end else if (h.ones == 4'd9) begin
                {h_next.hi5, h_next.hi4} = {h.hi5, h.hi4} + 2'd1;
                h_next.ones = 4'd0;
            end else begin
                h_next.ones = h.ones + 4'd1;
            end
        end
    end

    assign day_carry = inc && roll;

    always_ff @(posedge clk) begin
        if (rst)
            h <= '0;
        else if (load)
            h <= load_val;
        else if (inc)
            h <= h_next;
    end

    // R5: eleven becomes twelve with the half-day flag flipped
    a_r5_eleven_to_twelve: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && h.mode12 && h.hi4 && h.ones == 4'd1)
        |=> (h.hi4 && h.ones == 4'd2 && h.hi5 != $past(h.hi5)));

    // R4: 23 wraps to 00 in 24-hour mode
    a_r4_midnight_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !h.mode12 && h.hi5 && !h.hi4 && h.ones == 4'd3)
        |=> (!h.hi5 && !h.hi4 && h.ones == 4'd0));

    // R12: the mode bit is changed only by a load
    a_r12_mode_kept: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(h.mode12));

endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
    import bcd_cal_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  date_t load_val,
    input  logic  inc,
    output date_t d
);

    localparam date_t RESET_VAL = '{osc_off: 1'b1, rst_en: 1'b1, dow: 3'd1,
                                    date: 8'h01, month: 8'h01, year: 8'h00};

    logic month_end;
    assign month_end = (d.date == last_date(d.month, d.year));

    always_ff @(posedge clk) begin
        if (rst) begin
            d <= RESET_VAL;
        end else if (load) begin
            d <= load_val;
        end else if (inc) begin
            d.dow <= (d.dow == 3'd7) ? 3'd1 : d.dow + 3'd1;
            if (month_end) begin
                d.date <= 8'h01;
                if (d.month == 8'h12) begin
                    d.month <= 8'h01;
                    d.year  <= (d.year == 8'h99) ? 8'h00 : bcd_inc(d.year);
                end else begin
                    d.month <= bcd_inc(d.month);
                end
            end else begin
                d.date <= bcd_inc(d.date);
            end
        end
    end

    // R6: day of week wraps from 7 to 1
    a_r6_dow_wrap: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && d.dow == 3'd7) |=> (d.dow == 3'd1));

    // R8: February 28 of a leap year is followed by the 29th
    a_r8_leap_feb: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && d.month == 8'h02 && d.date == 8'h28 && is_leap(d.year))
        |=> (d.date == 8'h29 && d.month == 8'h02));

    // R12: control bits change only by a load
    a_r12_ctrl_kept: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable({d.osc_off, d.rst_en}));

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [BUS_W-1:0] load_data,
    output logic [BUS_W-1:0] regs_out
);

    cal_state_t ld;
    cal_state_t cur;
    logic       run_tick;
    logic       to_hour;
    logic       to_day;

    assign ld       = unpack_regs(load_data);
    assign run_tick = tick && !cur.d.osc_off && !load;

    cal_time_chain u_time (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_vals (ld.t),
        .inc       (run_tick),
        .vals      (cur.t),
        .carry_out (to_hour)
    );

    cal_hour_unit u_hour (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_val  (ld.h),
        .inc       (to_hour),
        .h         (cur.h),
        .day_carry (to_day)
    );

    cal_date_unit u_date (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (ld.d),
        .inc      (to_day),
        .d        (cur.d)
    );

    assign regs_out = pack_regs(cur);

    // R10: with the stop bit set and no load, nothing moves
    a_r10_stop_freezes: assert property (@(posedge clk) disable iff (rst)
        (cur.d.osc_off && !load) |=> $stable(regs_out));

    // R11: a load is visible in full on the next cycle
    a_r11_load_wins: assert property (@(posedge clk) disable iff (rst)
        load |=> (regs_out == ($past(load_data) & STORE_MASK)));

endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        load = 1'b0;
    logic [63:0] load_data = '0;
    logic [63:0] regs_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;
    string cur_tag = "R1";

    // behavioural model
    int m_hund, m_sec, m_min, m_hr, m_pm, m_mode12;
    int m_dow, m_date, m_mon, m_year, m_rsten, m_osc;

    always #5 clk = ~clk;

    bcd_calendar i_bcd_calendar (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load      (load),
        .load_data (load_data),
        .regs_out  (regs_out)
    );

    function automatic logic [7:0] to_bcd(int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic int month_len(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [63:0] model_image();
        logic [7:0] r3, r4;
        if (m_mode12 != 0)
            r3 = {1'b1, 1'b0, m_pm[0], to_bcd(m_hr)[4:0]};
        else
            r3 = {2'b00, to_bcd(m_hr)[5:0]};
        r4 = {2'b00, m_osc[0], m_rsten[0], 1'b0, m_dow[2:0]};
        return {to_bcd(m_year), to_bcd(m_mon), to_bcd(m_date), r4, r3,
                to_bcd(m_min), to_bcd(m_sec), to_bcd(m_hund)};
    endfunction

    task automatic model_new_day();
        m_dow = (m_dow == 7) ? 1 : m_dow + 1;
        m_date++;
        if (m_date > month_len(m_mon, m_year)) begin
            m_date = 1;
            m_mon++;
            if (m_mon > 12) begin
                m_mon  = 1;
                m_year = (m_year + 1) % 100;
            end
        end
    endtask

    task automatic model_tick();
        if (m_osc != 0) return;
        m_hund++;
        if (m_hund < 100) return;
        m_hund = 0; m_sec++;
        if (m_sec < 60) return;
        m_sec = 0; m_min++;
        if (m_min < 60) return;
        m_min = 0;
        if (m_mode12 != 0) begin
            if (m_hr == 11) begin
                m_hr = 12;
                m_pm = 1 - m_pm;
                if (m_pm == 0) model_new_day();
            end else if (m_hr == 12) begin
                m_hr = 1;
            end else begin
                m_hr++;
            end
        end else begin
            m_hr++;
            if (m_hr == 24) begin
                m_hr = 0;
                model_new_day();
            end
        end
    endtask

    task automatic compare();
        logic [63:0] exp_v;
        exp_v = model_image();
        n_tests++;
        if (regs_out !== exp_v) begin
            n_fail++;
            $display("FAIL %s: regs_out=%h expected=%h", cur_tag, regs_out, exp_v);
        end
    endtask

    // one clock without load; sample 1 ns after the edge
    task automatic cycle(input bit tk);
        @(negedge clk);
        tick = tk;
        load = 1'b0;
        if (tk) model_tick();
        @(posedge clk);
        #1;
        compare();
    endtask

    task automatic load_cycle(input int hu, input int se, input int mi,
                              input int md, input int hr, input int pm,
                              input int dw, input int re, input int os,
                              input int dt, input int mo, input int yr,
                              input bit tk);
        @(negedge clk);
        m_hund = hu; m_sec = se; m_min = mi; m_mode12 = md; m_hr = hr;
        m_pm = (md != 0) ? pm : 0;
        m_dow = dw; m_rsten = re; m_osc = os;
        m_date = dt; m_mon = mo; m_year = yr;
        load_data = model_image();
        load = 1'b1;
        tick = tk;
        @(posedge clk);
        #1;
        compare();
        @(negedge clk);
        load = 1'b0;
        tick = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) cycle(1'b1);
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        m_hund = 0; m_sec = 0; m_min = 0; m_hr = 0; m_pm = 0; m_mode12 = 0;
        m_dow = 1; m_date = 1; m_mon = 1; m_year = 0; m_rsten = 1; m_osc = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        cur_tag = "R1";
        compare();

        // R10: reset leaves the stop bit set, so ticks must not count
        cur_tag = "R10";
        run_ticks(5);

        // R2: start the clock and run through several hundredth wraps
        cur_tag = "R2";
        load_cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 1'b0);
        run_ticks(250);
        for (int i = 0; i < 20; i++) cycle(i[0]);

        // R3: seconds and minutes wrap
        cur_tag = "R3";
        load_cycle(97, 59, 58, 0, 5, 0, 2, 0, 0, 10, 3, 21, 1'b0);
        run_ticks(6);
        load_cycle(98, 59, 59, 0, 9, 0, 2, 0, 0, 10, 3, 21, 1'b0);
        run_ticks(4);

        // R4: 24-hour midnight and tens-of-hours bit
        cur_tag = "R4";
        load_cycle(98, 59, 59, 0, 19, 0, 3, 0, 0, 14, 5, 33, 1'b0);
        run_ticks(3);
        load_cycle(98, 59, 59, 0, 23, 0, 3, 0, 0, 14, 5, 33, 1'b0);
        run_ticks(3);

        // R5: 12-hour sequence 09->10, 11 AM->12 PM, 12 PM->01 PM, 11 PM->12 AM
        cur_tag = "R5";
        load_cycle(99, 59, 59, 1, 9, 0, 4, 0, 0, 20, 7, 40, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 1, 11, 0, 4, 0, 0, 20, 7, 40, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 1, 12, 1, 4, 0, 0, 20, 7, 40, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 1, 11, 1, 4, 0, 0, 20, 7, 40, 1'b0);
        run_ticks(2);

        // R6: day of week 7 -> 1
        cur_tag = "R6";
        load_cycle(99, 59, 59, 0, 23, 0, 7, 0, 0, 5, 8, 50, 1'b0);
        run_ticks(2);

        // R7: 30-day and 31-day month ends
        cur_tag = "R7";
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 30, 4, 50, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 30, 5, 50, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 30, 11, 50, 1'b0);
        run_ticks(2);

        // R8: February in leap and common years, 00 and 10 included
        cur_tag = "R8";
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 28, 2, 24, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 28, 2, 23, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 28, 2, 0, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 28, 2, 10, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 0, 23, 0, 1, 0, 0, 29, 2, 96, 1'b0);
        run_ticks(2);

        // R9: year end and century wrap
        cur_tag = "R9";
        load_cycle(99, 59, 59, 0, 23, 0, 6, 0, 0, 31, 12, 99, 1'b0);
        run_ticks(2);
        load_cycle(99, 59, 59, 0, 23, 0, 6, 0, 0, 31, 12, 45, 1'b0);
        run_ticks(2);

        // R10: stop bit freezes; load while stopped still applies
        cur_tag = "R10";
        load_cycle(42, 10, 10, 0, 10, 0, 2, 0, 1, 3, 3, 3, 1'b0);
        run_ticks(10);
        load_cycle(50, 20, 20, 0, 11, 0, 2, 0, 1, 4, 3, 3, 1'b1);
        run_ticks(5);

        // R11: load in the same cycle as a tick
        cur_tag = "R11";
        load_cycle(10, 0, 0, 0, 0, 0, 1, 0, 0, 1, 1, 1, 1'b1);
        run_ticks(3);

        // R12: control bits survive a full day rollover in 12-hour mode
        cur_tag = "R12";
        load_cycle(99, 59, 59, 1, 11, 1, 7, 1, 0, 31, 12, 99, 1'b0);
        run_ticks(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule